// File: doc/BRIEF.md
# Lane Inversion Write Codec

This block prepares one memory word for a cell array that wears with every cell that changes state. The data word is cut into byte lanes, and each lane is stored beside one flag bit that says whether the lane holds the byte as given or its bitwise complement. On a write, the caller supplies the new data and the vector that the target location holds now, which means a read always comes before a write. For each lane the block picks the form that changes fewer of the lane's stored cells.

It returns the new stored vector and a per-bit write-enable mask, so that only the cells that change are driven. A write request passes through a valid/ready handshake and its result comes back one cycle later from a registered output stage. That stage holds its result until the consumer accepts it. The read path is a separate combinational decoder. It turns a stored vector back into data by complementing each lane whose flag is set.

Top module: `lane_invert_codec`

## Requirements
- R1: After reset, `rsp_valid` is 0, and `req_ready` is 1 while `rsp_ready` is 1.
- R2: Stored lane i occupies bits [9i+8:9i]. Bits [9i+7:9i] hold the lane's byte, either true or complemented, and bit 9i+8 is the flag. A flag of 1 means the byte is complemented. Data lane i is `req_data[8i+7:8i]`.
- R3: For each lane, the encoder stores the true byte with flag 0 or the complemented byte with flag 1. It chooses whichever differs from the old 9-bit lane, flag included, in fewer bits.
- R4: `rsp_mask` equals the old stored vector XOR `rsp_vec`, bit for bit.
- R5: Within each lane, at most 4 of the 9 bits of `rsp_mask` are set.
- R6: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle, `rsp_valid` is 1 and `rsp_vec`/`rsp_mask` carry that request's result. Results come out in request order.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_vec` and `rsp_mask` stay stable and `req_ready` is 0.
- R8: `rd_data` is `rd_vec` decoded combinationally in the same cycle. Each lane's byte is complemented when its flag is 1, so decoding an encoder result gives back the data that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_data | input | 64 | New data word |
| req_old | input | 72 | Vector currently stored at the location |
| rsp_valid | output | 1 | Encoded result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_vec | output | 72 | New stored vector |
| rsp_mask | output | 72 | Per-bit write enable (changed cells) |
| rd_vec | input | 72 | Stored vector to decode |
| rd_data | output | 64 | Decoded data word |

## Verification
An encode result is due on the cycle after its request is accepted. The bench records the acceptance edge, confirms that `rsp_valid` is high at the following falling edge, and takes a queued expected result off the scoreboard only on cycles where the output handshake completes. This lets stalls of any length pass without the expected timing getting out of step. The decoder has zero latency. The bench drives each popped vector into `rd_vec` and compares `rd_data` after a short settle delay in the same cycle. During stalled cycles the bench compares the held outputs with the values from the previous cycle.

// File: rtl/lane_invert_codec.sv
module lane_invert_codec #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [LANES*LANE_W-1:0]        req_data,
  input  logic [LANES*(LANE_W+1)-1:0]    req_old,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [LANES*(LANE_W+1)-1:0]    rsp_vec,
  output logic [LANES*(LANE_W+1)-1:0]    rsp_mask,
  input  logic [LANES*(LANE_W+1)-1:0]    rd_vec,
  output logic [LANES*LANE_W-1:0]        rd_data
);
  localparam int SLOT = LANE_W + 1;
  localparam int SW   = LANES * SLOT;
  localparam int CW   = $clog2(SLOT + 1);

  logic [SW-1:0] nxt;
  logic          accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] d, od, diff;
    logic              of, inv;
    logic [CW-1:0]     h, cost_t, cost_c;

    assign d    = req_data[g*LANE_W +: LANE_W];
    assign od   = req_old[g*SLOT +: LANE_W];
    assign of   = req_old[g*SLOT + LANE_W];
    assign diff = d ^ od;

    always_comb begin
      h = '0;
      for (int b = 0; b < LANE_W; b++) h = h + CW'(diff[b]);
    end

    assign cost_t = h + CW'(of);
    assign cost_c = CW'(LANE_W) - h + CW'(!of);
    assign inv    = (cost_c < cost_t) || ((cost_c == cost_t) && of);

    assign nxt[g*SLOT +: SLOT] = {inv, inv ? ~d : d};

    assign rd_data[g*LANE_W +: LANE_W] =
      rd_vec[g*SLOT +: LANE_W] ^ {LANE_W{rd_vec[g*SLOT + LANE_W]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_vec   <= '0;
      rsp_mask  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_vec   <= nxt;
      rsp_mask  <= nxt ^ req_old;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_invert_codec_chk.sv
module lane_invert_codec_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [LANES*(LANE_W+1)-1:0] req_old,
  input logic                        rsp_valid,
  input logic                        rsp_ready,
  input logic [LANES*(LANE_W+1)-1:0] rsp_vec,
  input logic [LANES*(LANE_W+1)-1:0] rsp_mask
);
  localparam int SLOT = LANE_W + 1;

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  assert_mask_old_xor_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_mask == ($past(req_old) ^ rsp_vec));

  assert_result_next_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_vec) && $stable(rsp_mask));

  assert_no_accept_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  for (genvar g = 0; g < LANES; g++) begin : g_bound
    assert_lane_flip_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones(rsp_mask[g*SLOT +: SLOT]) <= SLOT/2);
  end
endmodule

bind lane_invert_codec lane_invert_codec_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_old(req_old), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_vec(rsp_vec), .rsp_mask(rsp_mask)
);

// File: tb/tb_lane_invert_codec.sv
module tb_lane_invert_codec;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8, LANE_W = 8, SLOT = 9;
  localparam int SW = LANES*SLOT, DW = LANES*LANE_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 1;
  logic [DW-1:0] req_data = '0, rd_data;
  logic [SW-1:0] req_old = '0, rsp_vec, rsp_mask, rd_vec = '0;

  lane_invert_codec #(.LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_old(req_old), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_vec(rsp_vec), .rsp_mask(rsp_mask),
    .rd_vec(rd_vec), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit bp_mode = 0, done = 0;
  logic [SW-1:0] q_vec[$], q_mask[$], stored;
  logic [DW-1:0] q_data[$];

  task automatic check(bit ok, string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [SW-1:0] model(logic [DW-1:0] d, logic [SW-1:0] old);
    logic [SW-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      logic [SLOT-1:0] a, b, o;
      o = old[i*SLOT +: SLOT];
      a = {1'b0, d[i*LANE_W +: LANE_W]};
      b = {1'b1, ~d[i*LANE_W +: LANE_W]};
      r[i*SLOT +: SLOT] = ($countones(a ^ o) <= $countones(b ^ o)) ? a : b;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    rsp_ready <= #1 bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    if (cyc == 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      summary();
    end
  end

  bit held = 0;
  logic [SW-1:0] held_vec, held_mask;
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (held)
        check(rsp_vec == held_vec && rsp_mask == held_mask, "R7 stall hold", rsp_vec, held_vec);
      if (!rsp_ready) begin
        held = 1; held_vec = rsp_vec; held_mask = rsp_mask;
        check(!req_ready, "R7 ready low in stall", SW'(req_ready), '0);
      end else begin
        held = 0;
        if (q_vec.size() == 0) check(0, "R6 unexpected result", rsp_vec, '0);
        else begin
          logic [SW-1:0] ev, em; logic [DW-1:0] ed;
          ev = q_vec.pop_front(); em = q_mask.pop_front(); ed = q_data.pop_front();
          check(rsp_vec == ev, "R3 R2 R6 vector", rsp_vec, ev);
          check(rsp_mask == em, "R4 mask", rsp_mask, em);
          for (int i = 0; i < LANES; i++)
            check($countones(rsp_mask[i*SLOT +: SLOT]) <= 4, "R5 lane flips",
                  SW'($countones(rsp_mask[i*SLOT +: SLOT])), SW'(4));
          rd_vec = rsp_vec;
          #1 check(rd_data == ed, "R8 decode round trip", SW'(rd_data), SW'(ed));
        end
      end
    end else held = 0;
  end

  task automatic send(logic [DW-1:0] d, logic [SW-1:0] old);
    logic [SW-1:0] e;
    bit r;
    e = model(d, old);
    q_vec.push_back(e); q_mask.push_back(e ^ old); q_data.push_back(d);
    stored = e;
    req_valid = 1; req_data = d; req_old = old;
    forever begin
      #1 r = req_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid, "R6 valid after accept", SW'(rsp_valid), SW'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!rsp_valid, "R1 valid low in reset", SW'(rsp_valid), '0);
    rst_n = 1;
    @(negedge clk);
    #2;
    check(!rsp_valid && req_ready, "R1 idle after reset", SW'({rsp_valid, req_ready}), SW'(1));
    @(negedge clk);
    send('0, '0);
    send({DW{1'b1}}, '0);
    begin
      logic [SW-1:0] allflag;
      allflag = '0;
      for (int i = 0; i < LANES; i++) allflag[i*SLOT + LANE_W] = 1'b1;
      send({DW{1'b1}}, allflag);
      send('0, allflag);
      send(64'h0F0F_F0F0_0F1F_E0F0, allflag);
    end
    for (int k = 0; k < 30; k++)
      send({$urandom, $urandom}, SW'({$urandom, $urandom, $urandom}));
    for (int k = 0; k < 30; k++) send({$urandom, $urandom}, stored);
    bp_mode = 1;
    for (int k = 0; k < 40; k++) send({$urandom, $urandom}, stored);
    while (q_vec.size() != 0) @(negedge clk);
    bp_mode = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule